// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block moves 8-bit words between two ports, A and B, through two independent latch banks, one per direction. Each direction is steered by three active-low controls: a chip enable, a latch enable and an output enable. While the chip enable and the latch enable are both low, the bank follows its source port. Raising either of the two freezes the stored word, which can then be presented on the far port as long as the chip enable and the output enable of that direction are both low.

Each latch bank is modelled as a register sampled on the system clock, so a word that is taken in at one rising edge shows up on the far port from that edge onward. The chip enable and the latch enable act together as one effective load enable, which is their OR. Each far-side output is modelled as a data bus paired with a drive-enable flag, standing in for a three-state driver. When the drive enable is low, the data bus is forced to zero.

Top module: `duplex_latch_xcvr`

## Requirements
- R1: While rst_n is low both latch banks clear to zero and both drive enables (bOutEn, aOutEn) are low; after release, an enabled output shows zero until a word is loaded.
- R2: At a rising clock edge where ceAbN=0 and leAbN=0, the A-to-B bank takes aIn; from that edge on, bOut shows that word whenever bOutEn is high.
- R3: At edges where leAbN=1, the A-to-B bank keeps its stored word.
- R4: At edges where ceAbN=1, the A-to-B bank keeps its stored word even with leAbN=0.
- R5: bOutEn is high in the same cycle exactly when rst_n=1, ceAbN=0 and oeAbN=0. aOutEn is high exactly when rst_n=1, ceBaN=0 and oeBaN=0.
- R6: While a drive enable is low, its data bus (bOut or aOut) is all zeros.
- R7: The B-to-A bank follows the same rules using bIn, ceBaN, leBaN and oeBaN, and its word appears on aOut.
- R8: The two directions are independent. With both banks loading and both outputs enabled in the same cycle, each far port carries the word from its own source.
- R9: The output enable does not affect loading. A word loaded while oeAbN=1 or oeBaN=1 is shown once that output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| aIn | input | 8 | Word sensed on port A |
| bIn | input | 8 | Word sensed on port B |
| ceAbN | input | 1 | A-to-B chip enable, active low |
| leAbN | input | 1 | A-to-B latch enable, active low |
| oeAbN | input | 1 | A-to-B output enable, active low |
| ceBaN | input | 1 | B-to-A chip enable, active low |
| leBaN | input | 1 | B-to-A latch enable, active low |
| oeBaN | input | 1 | B-to-A output enable, active low |
| aOut | output | 8 | Word driven onto port A |
| aOutEn | output | 1 | Drive enable for port A |
| bOut | output | 8 | Word driven onto port B |
| bOutEn | output | 1 | Drive enable for port B |

## Verification
The hardest case to reach is a load that ends because the chip enable rises while the latch enable stays low. That hold can only be seen later, once the output is enabled again, because a high chip enable also blanks the output. Directed sequences load a word and raise the chip enable with the latch enable still low. They then change the source word, lower the chip enable again with the latch enable high, and read the held word. Random traffic with the controls biased toward low adds overlapping activity in both directions.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int NUM_DIRS = 2;
  localparam int DIR_AB   = 0;
  localparam int DIR_BA   = 1;

  typedef struct packed {
    logic load;
    logic drive;
  } dirStrobe_t;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic                          rst_n,
  input  logic [NUM_DIRS-1:0]           ceN,
  input  logic [NUM_DIRS-1:0]           leN,
  input  logic [NUM_DIRS-1:0]           oeN,
  output dirStrobe_t [NUM_DIRS-1:0]     strb
);

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    logic loadGateN;
    logic driveGateN;

    // effective load enable is the OR of chip and latch enables
    assign loadGateN = ceN[d] | leN[d];
    assign driveGateN = ceN[d] | oeN[d];

    always_comb begin
      strb[d].load  = rst_n & ~loadGateN;
      strb[d].drive = rst_n & ~driveGateN;
    end
  end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  dirStrobe_t [NUM_DIRS-1:0]           strb,
  input  logic [NUM_DIRS-1:0][DATA_W-1:0]     din,
  output logic [NUM_DIRS-1:0][DATA_W-1:0]     dout,
  output logic [NUM_DIRS-1:0]                 doutEn
);

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_bank
    logic [DATA_W-1:0] store;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        store <= '0;
      end else if (strb[d].load) begin
        store <= din[d];
      end
    end

    always_comb begin
      doutEn[d] = strb[d].drive;
      dout[d]   = strb[d].drive ? store : '0;
    end
  end

endmodule

// File: rtl/duplex_latch_xcvr.sv
module duplex_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              ceAbN,
  input  logic              leAbN,
  input  logic              oeAbN,
  input  logic              ceBaN,
  input  logic              leBaN,
  input  logic              oeBaN,
  output logic [DATA_W-1:0] aOut,
  output logic              aOutEn,
  output logic [DATA_W-1:0] bOut,
  output logic              bOutEn
);

  dirStrobe_t [NUM_DIRS-1:0]       strb;
  logic [NUM_DIRS-1:0]             ceN, leN, oeN;
  logic [NUM_DIRS-1:0][DATA_W-1:0] din, dout;
  logic [NUM_DIRS-1:0]             doutEn;

  always_comb begin
    ceN[DIR_AB] = ceAbN;  leN[DIR_AB] = leAbN;  oeN[DIR_AB] = oeAbN;
    ceN[DIR_BA] = ceBaN;  leN[DIR_BA] = leBaN;  oeN[DIR_BA] = oeBaN;
    din[DIR_AB] = aIn;
    din[DIR_BA] = bIn;
  end

  xcvr_ctrl u_ctrl (
    .rst_n (rst_n),
    .ceN   (ceN),
    .leN   (leN),
    .oeN   (oeN),
    .strb  (strb)
  );

  xcvr_path #(.DATA_W(DATA_W)) u_path (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .din    (din),
    .dout   (dout),
    .doutEn (doutEn)
  );

  assign bOut   = dout[DIR_AB];
  assign bOutEn = doutEn[DIR_AB];
  assign aOut   = dout[DIR_BA];
  assign aOutEn = doutEn[DIR_BA];

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] aIn,
  input logic [DATA_W-1:0] bIn,
  input logic              ceAbN,
  input logic              leAbN,
  input logic              ceBaN,
  input logic              leBaN,
  input logic [DATA_W-1:0] aOut,
  input logic              aOutEn,
  input logic [DATA_W-1:0] bOut,
  input logic              bOutEn
);

  // R1: first cycle after reset release shows a cleared bank
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) && bOutEn |-> bOut == '0);

  // R2: a load edge is visible on bOut afterwards
  a_r2_ab_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!ceAbN && !leAbN) && bOutEn |-> bOut == $past(aIn));

  // R3: latch enable high keeps the word steady
  a_r3_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(leAbN) && $past(bOutEn) && bOutEn |-> bOut == $past(bOut));

  // R6: disabled outputs are zero
  a_r6_b_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !bOutEn |-> bOut == '0);
  a_r6_a_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !aOutEn |-> aOut == '0);

  // R7: B-to-A load and hold
  a_r7_ba_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!ceBaN && !leBaN) && aOutEn |-> aOut == $past(bIn));
  a_r7_ba_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(leBaN) && $past(aOutEn) && aOutEn |-> aOut == $past(aOut));

endmodule

bind duplex_latch_xcvr xcvr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .aIn    (aIn),
  .bIn    (bIn),
  .ceAbN  (ceAbN),
  .leAbN  (leAbN),
  .ceBaN  (ceBaN),
  .leBaN  (leBaN),
  .aOut   (aOut),
  .aOutEn (aOutEn),
  .bOut   (bOut),
  .bOutEn (bOutEn)
);

// File: tb/sim_duplex_latch_xcvr.sv
module sim_duplex_latch_xcvr;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic ceAbN = 1'b1, leAbN = 1'b1, oeAbN = 1'b1;
  logic ceBaN = 1'b1, leBaN = 1'b1, oeBaN = 1'b1;
  logic [W-1:0] aOut, bOut;
  logic aOutEn, bOutEn;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] abExp = '0, baExp = '0;
  logic abLoaded = 1'b0, baLoaded = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  duplex_latch_xcvr #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .aIn(aIn), .bIn(bIn),
    .ceAbN(ceAbN), .leAbN(leAbN), .oeAbN(oeAbN),
    .ceBaN(ceBaN), .leBaN(leBaN), .oeBaN(oeBaN),
    .aOut(aOut), .aOutEn(aOutEn), .bOut(bOut), .bOutEn(bOutEn)
  );

  function automatic logic [W-1:0] nextStore(logic [W-1:0] cur, logic [W-1:0] d,
                                             logic ce, logic le);
    return (!ce && !le) ? d : cur;
  endfunction

  function automatic logic [W-1:0] shown(logic [W-1:0] st, logic en);
    return en ? st : '0;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock step: inputs already driven; update model at the edge, check at next negedge
  task automatic step(string abTag, string baTag);
    logic enB, enA;
    @(posedge clk);
    abLoaded = !ceAbN && !leAbN;
    baLoaded = !ceBaN && !leBaN;
    abExp = nextStore(abExp, aIn, ceAbN, leAbN);
    baExp = nextStore(baExp, bIn, ceBaN, leBaN);
    @(negedge clk);
    enB = !ceAbN && !oeAbN;
    enA = !ceBaN && !oeBaN;
    check("R5 bOutEn", {7'd0, bOutEn}, {7'd0, enB});
    check("R5 aOutEn", {7'd0, aOutEn}, {7'd0, enA});
    check(enB ? abTag : "R6 bOut", bOut, shown(abExp, enB));
    check(enA ? baTag : "R6 aOut", aOut, shown(baExp, enA));
  endtask

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b,
                       logic cab, logic lab, logic oab,
                       logic cba, logic lba, logic oba);
    aIn = a; bIn = b;
    ceAbN = cab; leAbN = lab; oeAbN = oab;
    ceBaN = cba; leBaN = lba; oeBaN = oba;
  endtask

  initial begin
    // R1: reset state
    drive(8'hA5, 8'h5A, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 bOutEn in reset", {7'd0, bOutEn}, 8'd0);
    check("R1 aOutEn in reset", {7'd0, aOutEn}, 8'd0);
    check("R1 bOut in reset", bOut, 8'd0);
    drive(8'hA5, 8'h5A, 0, 1, 0, 0, 1, 0);
    rst_n = 1'b1;
    step("R1 cleared B", "R1 cleared A");

    // R2 / R7 load, then R3 hold with source changing
    drive(8'h3C, 8'hC3, 0, 0, 0, 0, 0, 0);
    step("R2 ab load", "R7 ba load");
    drive(8'h11, 8'h22, 0, 1, 0, 0, 1, 0);
    step("R3 ab hold", "R7 ba hold");
    step("R3 ab hold", "R7 ba hold");

    // R4: chip enable high with latch enable low freezes, output blanks
    drive(8'h77, 8'h88, 0, 0, 0, 0, 0, 0);
    step("R2 ab load", "R7 ba load");
    drive(8'h99, 8'h66, 1, 0, 0, 1, 0, 0);
    step("R4 ab ce hold", "R4 ba ce hold");
    drive(8'h55, 8'hAA, 1, 0, 0, 1, 0, 0);
    step("R4 ab ce hold", "R4 ba ce hold");
    drive(8'hF0, 8'h0F, 0, 1, 0, 0, 1, 0);
    step("R4 ab held word", "R4 ba held word");

    // R9: load with outputs disabled, then enable
    drive(8'hDE, 8'hAD, 0, 0, 1, 0, 0, 1);
    step("R9 ab", "R9 ba");
    drive(8'h00, 8'hFF, 0, 1, 0, 0, 1, 0);
    step("R9 ab shown", "R9 ba shown");

    // R8: both directions loading and driving together, distinct words
    drive(8'h12, 8'h34, 0, 0, 0, 0, 0, 0);
    step("R8 ab both", "R8 ba both");
    drive(8'h56, 8'h78, 0, 0, 0, 1, 1, 1);
    step("R8 ab alone", "R8 ba idle");

    // constrained random mix, controls biased low
    for (int i = 0; i < 2000; i++) begin
      logic [2:0] ab, ba;
      ab = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
      ba = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
      drive(8'($urandom), 8'($urandom), ab[0], ab[1], ab[2], ba[0], ba[1], ba[2]);
      step(ab[1] ? "R3 ab rand" : "R2 ab rand", ba[1] ? "R7 ba hold rand" : "R7 ba rand");
    end

    done = 1'b1;
  end

  initial begin
    void'($urandom(32'd1234));
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule